// File: doc/BRIEF.md
# Event-Driven Channel Scheduler

This block picks which of 32 DMA channels an execution core should run next. Peripheral request lines (events) are latched as pending and routed to channels through a programmable matrix: one 32-bit word per event, one bit per channel. A channel becomes a candidate when host software has marked it runnable, has given it a nonzero 3-bit priority, and either one of its mapped events is pending or it has been told to ignore events. Among the candidates the highest priority wins. Ties go to the higher-numbered channel.

The winner is presented to the core as a held grant (`gnt_valid`, `gnt_chan`) until the core pulses `core_done`. On completion the channel leaves the runnable set and its bit in the interrupt status word is set. The host reaches all state through a simple word-addressed register bus. Write strobes on the start, stop and interrupt words act only on the bits written as one. Channel 0 is the host's command channel and always ignores event gating.

Top module: `evt_chan_sched`

## Requirements
- R1: Reset clears every register. After reset `gnt_valid` and `irq` are 0 and every register reads 0.
- R2: A write to word 0x00 sets runnable bit n for every data bit n that is 1. Zero bits leave their channels unchanged. Words 0x00 and 0x01 both read back the runnable vector.
- R3: A write to word 0x01 clears runnable bit n for every data bit n that is 1. A grant already issued stays in place until `core_done`.
- R4: Word 0x40+n holds the 3-bit priority of channel n (data bits 2:0). A channel with priority 0 is never granted, even with its event gating overridden.
- R5: Word 0x80+e (e below the event count, 48 by default) holds the channel mask of event e, where bit c maps event e to channel c. A channel without override is granted only when it is runnable, its priority is nonzero and a pending event mapped to it exists. Words for event indices at or above the event count ignore writes and read 0.
- R6: Bit c of word 0x03 makes channel c ignore event gating, so it runs on its runnable bit alone. Channel 0 always behaves as if this bit were set.
- R7: Among eligible channels the highest priority is granted. On equal priority the higher channel number wins. When idle with an eligible channel, `gnt_valid` rises on the next clock edge.
- R8: `gnt_valid` and `gnt_chan` hold steady until `core_done` is seen with `gnt_valid` high. `gnt_valid` is then low for at least one cycle before the next grant.
- R9: An accepted `core_done` clears the granted channel's runnable bit and sets its bit in word 0x02. `irq` is the OR of word 0x02.
- R10: Writing ones to word 0x02 clears those interrupt bits. A completion in the same cycle wins over the clear.
- R11: An `evt_req` bit latches into pending state, readable as word 0x04 (events 0 to 31) and word 0x05 (events 32 and up, from bit 0). A grant clears only the pending events whose mask includes the granted channel. A request arriving in the same cycle wins over the clear.
- R12: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled, and is 0 in any other cycle. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_req | input | 48 | Peripheral event request lines |
| gnt_valid | output | 1 | Grant to the execution core is active |
| gnt_chan | output | 5 | Granted channel number |
| core_done | input | 1 | Core finished the granted channel |
| irq | output | 1 | Any interrupt status bit set |

## Verification
Wrong internal state shows up at the ports quickly. A corrupted runnable, priority, override or matrix bit changes which channel wins the next grant or delays it, and a per-cycle reference model catches that on the very edge it happens. Pending-event and interrupt errors show as a wrong `irq` in the cycle after completion, or as a wrong readback one cycle after a read. Directed sequences cover each requirement: ties, priority zero, partial event clearing, completion racing a clear, and stop during a grant. A long random phase then compares grant, interrupt and read data every clock.

// File: rtl/esch_pkg.sv
package esch_pkg;
  // Word addresses of the register map.
  localparam int unsigned ADR_RUN_SET = 'h00;
  localparam int unsigned ADR_RUN_CLR = 'h01;
  localparam int unsigned ADR_INT     = 'h02;
  localparam int unsigned ADR_FREE    = 'h03;
  localparam int unsigned ADR_PEND    = 'h04;
  localparam int unsigned ADR_PRIO    = 'h40;
  localparam int unsigned ADR_EMAP    = 'h80;
  // Host command channel, never gated by events.
  localparam int unsigned CMD_CHAN    = 0;
endpackage

// File: rtl/esch_regs.sv
module esch_regs
  import esch_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int NEVT = 48,
  parameter int PW   = 3,
  parameter int AW   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [AW-1:0]             bus_addr,
  input  logic [NCH-1:0]            bus_wdata,
  output logic [NCH-1:0]            bus_rdata,
  input  logic                      fin,
  input  logic [$clog2(NCH)-1:0]    fin_chan,
  input  logic [NEVT-1:0]           pend,
  output logic [NCH-1:0]            run,
  output logic [NCH-1:0]            intst,
  output logic [NCH-1:0]            ovr,
  output logic [NCH-1:0][PW-1:0]    prio,
  output logic [NEVT-1:0][NCH-1:0]  emap
);
  localparam int NPW = (NEVT + NCH - 1) / NCH;

  logic [NCH-1:0]     fin_mask;
  logic [NCH-1:0]     set_bits, clr_bits, ack_bits;
  logic [NCH-1:0]     rd_nxt;
  logic [NPW*NCH-1:0] pend_pad;

  assign fin_mask = fin ? (NCH'(1) << fin_chan) : '0;
  assign set_bits = (bus_wr && bus_addr == AW'(ADR_RUN_SET)) ? bus_wdata : '0;
  assign clr_bits = (bus_wr && bus_addr == AW'(ADR_RUN_CLR)) ? bus_wdata : '0;
  assign ack_bits = (bus_wr && bus_addr == AW'(ADR_INT))     ? bus_wdata : '0;
  assign pend_pad = (NPW*NCH)'(pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= '0;
      intst <= '0;
      ovr   <= '0;
    end else begin
      run   <= (run & ~fin_mask & ~clr_bits) | set_bits;
      intst <= (intst & ~ack_bits) | fin_mask;
      if (bus_wr && bus_addr == AW'(ADR_FREE)) ovr <= bus_wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst)
        prio[c] <= '0;
      else if (bus_wr && bus_addr == AW'(ADR_PRIO + c))
        prio[c] <= bus_wdata[PW-1:0];
    end
  end

  for (genvar e = 0; e < NEVT; e++) begin : g_emap
    always_ff @(posedge clk) begin
      if (rst)
        emap[e] <= '0;
      else if (bus_wr && bus_addr == AW'(ADR_EMAP + e))
        emap[e] <= bus_wdata;
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == AW'(ADR_RUN_SET) || bus_addr == AW'(ADR_RUN_CLR)) rd_nxt = run;
    if (bus_addr == AW'(ADR_INT))  rd_nxt = intst;
    if (bus_addr == AW'(ADR_FREE)) rd_nxt = ovr;
    for (int k = 0; k < NPW; k++)
      if (bus_addr == AW'(ADR_PEND + k)) rd_nxt = pend_pad[k*NCH +: NCH];
    for (int c = 0; c < NCH; c++)
      if (bus_addr == AW'(ADR_PRIO + c)) rd_nxt = NCH'(prio[c]);
    for (int e = 0; e < NEVT; e++)
      if (bus_addr == AW'(ADR_EMAP + e)) rd_nxt = emap[e];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_nxt : '0;
  end
endmodule

// File: rtl/esch_elig.sv
module esch_elig
  import esch_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int NEVT = 48,
  parameter int PW   = 3
) (
  input  logic [NCH-1:0]            run,
  input  logic [NCH-1:0]            ovr,
  input  logic [NCH-1:0][PW-1:0]    prio,
  input  logic [NEVT-1:0][NCH-1:0]  emap,
  input  logic [NEVT-1:0]           pend,
  output logic [NCH-1:0]            elig
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NEVT-1:0] col;
    always_comb begin
      for (int e = 0; e < NEVT; e++) col[e] = emap[e][c] & pend[e];
    end
    assign elig[c] = run[c] && (prio[c] != '0) &&
                     ((c == CMD_CHAN) || ovr[c] || (|col));
  end
endmodule

// File: rtl/esch_arb.sv
module esch_arb #(
  parameter int NCH = 32,
  parameter int PW  = 3
) (
  input  logic [NCH-1:0]           elig,
  input  logic [NCH-1:0][PW-1:0]   prio,
  output logic                     any,
  output logic [$clog2(NCH)-1:0]   pick
);
  localparam int CW = $clog2(NCH);
  logic [PW-1:0] best;

  // Scan upward; ">=" lets a later channel take an equal priority.
  always_comb begin
    any  = 1'b0;
    pick = '0;
    best = '0;
    for (int c = 0; c < NCH; c++) begin
      if (elig[c] && prio[c] >= best) begin
        best = prio[c];
        pick = CW'(c);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_chan_sched.sv
module evt_chan_sched #(
  parameter int NCH  = 32,
  parameter int NEVT = 48,
  parameter int PW   = 3,
  parameter int AW   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [AW-1:0]           reg_addr,
  input  logic [NCH-1:0]          reg_wdata,
  output logic [NCH-1:0]          reg_rdata,
  input  logic [NEVT-1:0]         evt_req,
  output logic                    gnt_valid,
  output logic [$clog2(NCH)-1:0]  gnt_chan,
  input  logic                    core_done,
  output logic                    irq
);
  localparam int CW = $clog2(NCH);

  logic [NCH-1:0]           run, intst, ovr, elig;
  logic [NCH-1:0][PW-1:0]   prio;
  logic [NEVT-1:0][NCH-1:0] emap;
  logic [NEVT-1:0]          pend, pclr;
  logic                     any, take, fin;
  logic [CW-1:0]            pick;

  assign fin  = gnt_valid & core_done;
  assign take = ~gnt_valid & any;

  esch_regs #(.NCH(NCH), .NEVT(NEVT), .PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(reg_wr), .bus_rd(reg_rd), .bus_addr(reg_addr),
    .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .fin(fin), .fin_chan(gnt_chan), .pend(pend),
    .run(run), .intst(intst), .ovr(ovr), .prio(prio), .emap(emap)
  );

  esch_elig #(.NCH(NCH), .NEVT(NEVT), .PW(PW)) u_elig (
    .run(run), .ovr(ovr), .prio(prio), .emap(emap), .pend(pend), .elig(elig)
  );

  esch_arb #(.NCH(NCH), .PW(PW)) u_arb (
    .elig(elig), .prio(prio), .any(any), .pick(pick)
  );

  always_comb begin
    for (int e = 0; e < NEVT; e++) pclr[e] = take & emap[e][pick];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      gnt_valid <= 1'b0;
      gnt_chan  <= '0;
    end else begin
      pend <= (pend & ~pclr) | evt_req;
      if (take) begin
        gnt_valid <= 1'b1;
        gnt_chan  <= pick;
      end else if (fin) begin
        gnt_valid <= 1'b0;
      end
    end
  end

  assign irq = |intst;
endmodule

// File: rtl/esch_chk.sv
module esch_chk #(
  parameter int NCH = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   gnt_valid,
  input logic [$clog2(NCH)-1:0] gnt_chan,
  input logic                   core_done,
  input logic                   irq,
  input logic [NCH-1:0]         elig
);
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst) (gnt_valid && !core_done) |=> (gnt_valid && $stable(gnt_chan))); // R8
  AST_GNT_GAP: assert property (@(posedge clk) disable iff (rst) (gnt_valid && core_done) |=> !gnt_valid); // R8
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (rst) (gnt_valid && core_done) |=> irq); // R9
  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (rst) (!gnt_valid && elig != '0) |=> gnt_valid); // R7
  AST_NO_ELIG_IDLE: assert property (@(posedge clk) disable iff (rst) (!gnt_valid && elig == '0) |=> !gnt_valid); // R5
endmodule

bind evt_chan_sched esch_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .gnt_valid(gnt_valid), .gnt_chan(gnt_chan),
  .core_done(core_done), .irq(irq), .elig(elig)
);

// File: tb/tb_evt_chan_sched.sv
`timescale 1ns/1ps
module tb_evt_chan_sched;
  localparam int NCH = 32, NEVT = 48, PW = 3, AW = 8;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [NCH-1:0] reg_wdata = '0;
  logic [NCH-1:0] reg_rdata;
  logic [NEVT-1:0] evt_req = '0;
  logic gnt_valid, core_done = 0, irq;
  logic [4:0] gnt_chan;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  evt_chan_sched #(.NCH(NCH), .NEVT(NEVT), .PW(PW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_req(evt_req),
    .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .core_done(core_done), .irq(irq)
  );

  // Behavioural reference model
  bit [31:0] m_run, m_int, m_ovr, m_rdata;
  bit [2:0]  m_prio [32];
  bit [31:0] m_emap [48];
  bit [47:0] m_pend;
  bit        m_busy;
  int        m_gch;

  task automatic model_step();
    int a, best, bp;
    bit el, hit;
    bit [31:0] rv, w, n_run, n_int;
    bit [47:0] n_pend;
    a = reg_addr; w = reg_wdata; rv = 0;
    if (reg_rd) begin
      if (a == 0 || a == 1) rv = m_run;
      else if (a == 2) rv = m_int;
      else if (a == 3) rv = m_ovr;
      else if (a == 4) rv = m_pend[31:0];
      else if (a == 5) rv = {16'h0, m_pend[47:32]};
      else if (a >= 64 && a < 96) rv = {29'h0, m_prio[a-64]};
      else if (a >= 128 && a < 176) rv = m_emap[a-128];
    end
    best = -1; bp = 0;
    if (!m_busy) begin
      for (int c = 0; c < 32; c++) begin
        hit = 0;
        for (int e = 0; e < 48; e++) if (m_pend[e] && m_emap[e][c]) hit = 1;
        el = m_run[c] && m_prio[c] != 0 && (c == 0 || m_ovr[c] || hit);
        if (el && m_prio[c] >= bp) begin bp = m_prio[c]; best = c; end
      end
    end
    n_run = m_run; n_int = m_int; n_pend = m_pend;
    if (m_busy && core_done) n_run[m_gch] = 0;
    if (reg_wr && a == 1) n_run &= ~w;
    if (reg_wr && a == 0) n_run |= w;
    if (reg_wr && a == 2) n_int &= ~w;
    if (m_busy && core_done) n_int[m_gch] = 1;
    if (best >= 0)
      for (int e = 0; e < 48; e++) if (m_emap[e][best]) n_pend[e] = 0;
    n_pend |= evt_req;
    if (m_busy && core_done) m_busy = 0;
    else if (!m_busy && best >= 0) begin m_busy = 1; m_gch = best; end
    if (reg_wr && a == 3) m_ovr = w;
    if (reg_wr && a >= 64 && a < 96) m_prio[a-64] = w[2:0];
    if (reg_wr && a >= 128 && a < 176) m_emap[a-128] = w;
    m_run = n_run; m_int = n_int; m_pend = n_pend; m_rdata = rv;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_int = 0; m_ovr = 0; m_rdata = 0; m_pend = 0; m_busy = 0; m_gch = 0;
      for (int i = 0; i < 32; i++) m_prio[i] = 0;
      for (int i = 0; i < 48; i++) m_emap[i] = 0;
    end else model_step();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R8 model gnt_valid", 64'(gnt_valid), 64'(m_busy));
      if (m_busy) chk("R7 model gnt_chan", 64'(gnt_chan), 64'(m_gch));
      chk("R9 model irq", 64'(irq), 64'(m_int != 0));
      chk("R12 model rdata", 64'(reg_rdata), 64'(m_rdata));
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog act=%0d exp=<150000", cyc);
      report();
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = AW'(a);
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_gnt(input int exp, input string tag);
    int n = 0;
    while (!gnt_valid && n < 20) begin @(negedge clk); n++; end
    chk(tag, gnt_valid ? 64'(gnt_chan) : 64'd99, 64'(exp));
  endtask

  task automatic done_pulse();
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
  endtask

  task automatic pulse_evt(input logic [47:0] m);
    @(negedge clk); evt_req = m;
    @(negedge clk); evt_req = '0;
  endtask

  logic [31:0] v;

  initial begin
    tick(4);
    rst = 0; cmp_on = 1;
    tick(1);
    // R1 reset state
    chk("R1 gnt_valid", 64'(gnt_valid), 0);
    chk("R1 irq", 64'(irq), 0);
    rd(0, v); chk("R1 run word", 64'(v), 0);
    rd('h45, v); chk("R1 prio word", 64'(v), 0);
    // R2 start, zero bits have no effect
    wr(0, 32'h2006); rd(0, v); chk("R2 run after start", 64'(v), 64'h2006);
    wr(0, 32'h0008); rd(1, v); chk("R2 zero bits kept", 64'(v), 64'h200E);
    // R4 priority zero never granted, even with override
    wr(3, 32'h2000); tick(5); chk("R4 prio0 no grant", 64'(gnt_valid), 0);
    wr(1, 32'h2000);
    // R5 no event, no grant
    wr('h41, 3); wr('h42, 3); wr('h43, 2); wr(3, 0);
    tick(5); chk("R5 no event no grant", 64'(gnt_valid), 0);
    wr('h85, 32'h2); pulse_evt(48'h20);
    wait_gnt(1, "R5 event grant ch1");
    rd(4, v); chk("R11 pend cleared on grant", 64'(v), 0);
    // R9 completion
    done_pulse();
    chk("R9 irq after done", 64'(irq), 1);
    rd(0, v); chk("R9 run cleared", 64'(v), 64'hC);
    rd(2, v); chk("R9 int bit", 64'(v), 64'h2);
    // R10 clear
    wr(2, 32'h2); rd(2, v); chk("R10 int cleared", 64'(v), 0);
    chk("R10 irq low", 64'(irq), 0);
    // R6 override, R7 priority order
    wr(3, 32'hC);
    wait_gnt(2, "R7 higher prio ch2");
    done_pulse();
    wait_gnt(3, "R6 override ch3");
    done_pulse();
    // R7 tie to higher number
    wr('h44, 5); wr('h49, 5); wr(3, 32'h21C); wr(0, 32'h210);
    wait_gnt(9, "R7 tie ch9");
    done_pulse();
    wait_gnt(4, "R7 tie then ch4");
    done_pulse();
    // R6 command channel needs no event
    wr('h40, 7); wr(0, 32'h1);
    wait_gnt(0, "R6 ch0 command");
    done_pulse();
    // R3 stop
    wr('h45, 1); wr(0, 32'h20); wr(1, 32'h20);
    rd(0, v); chk("R3 stop clears run", 64'(v), 0);
    wr('h46, 2); wr(3, 32'h25C); wr(0, 32'h40);
    wait_gnt(6, "R3 ch6 grant");
    wr(1, 32'h40);
    chk("R3 grant kept after stop", 64'(gnt_valid), 1);
    wr(0, 32'h200); tick(3);
    chk("R8 grant held", 64'(gnt_chan), 6);
    done_pulse();
    wait_gnt(9, "R8 next grant after done");
    done_pulse();
    // R11 event latch for upper word
    wr('h80 + 40, 32'h80); pulse_evt(48'h1 << 40);
    rd(5, v); chk("R11 pend upper word", 64'(v), 64'h100);
    wr('h47, 4); wr(0, 32'h80);
    wait_gnt(7, "R5 ch7 on event 40");
    rd(5, v); chk("R11 pend upper cleared", 64'(v), 0);
    done_pulse();
    // R5 out of range event, R12 unmapped
    wr('h80 + 50, 32'hFFFF); rd('h80 + 50, v); chk("R5 event beyond count", 64'(v), 0);
    rd('h20, v); chk("R12 unmapped", 64'(v), 0);
    // R11 only mapped events clear
    wr('h8A, 32'h800); wr('h8B, 32'h1000); pulse_evt(48'hC00);
    wr('h4B, 6); wr(0, 32'h800);
    wait_gnt(11, "R11 ch11 grant");
    rd(4, v); chk("R11 partial clear", 64'(v), 64'h800);
    done_pulse();
    // R10 completion beats clear
    wr(0, 32'h10);
    wait_gnt(4, "R10 ch4 grant");
    @(negedge clk); core_done = 1; reg_wr = 1; reg_addr = 8'h02; reg_wdata = 32'h10;
    @(negedge clk); core_done = 0; reg_wr = 0;
    rd(2, v); chk("R10 set wins", 64'(v[4]), 1);
    // Random phase compared every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      int sel;
      @(negedge clk);
      sel = int'($urandom_range(0, 9));
      reg_wr = ($urandom_range(0, 3) == 0);
      reg_rd = ($urandom_range(0, 2) == 0);
      case (sel)
        0: reg_addr = 8'h00;
        1: reg_addr = 8'h01;
        2: reg_addr = 8'h02;
        3: reg_addr = 8'h03;
        4: reg_addr = 8'h04;
        5: reg_addr = 8'h05;
        6, 7: reg_addr = AW'(8'h40 + $urandom_range(0, 31));
        8: reg_addr = AW'(8'h80 + $urandom_range(0, 47));
        default: reg_addr = AW'($urandom_range(0, 255));
      endcase
      reg_wdata = $urandom() & $urandom();
      evt_req = ($urandom_range(0, 3) == 0) ? (48'h1 << $urandom_range(0, 47)) : '0;
      core_done = gnt_valid && ($urandom_range(0, 2) == 0);
    end
    @(negedge clk); reg_wr = 0; reg_rd = 0; evt_req = '0; core_done = 0;
    tick(5);
    report();
  end
endmodule